// File: doc/BRIEF.md
# Single-Phase PWM Generator with Dead-Band Insertion

This block produces the gate drive pair for one half-bridge leg. A prescaled counter runs either as a sawtooth (edge-aligned) or as an up/down triangle (center-aligned). Its value is compared against an active duty value, and the compare result feeds a dead-band stage. That stage outputs a high-side and a low-side drive.

Software sets the block up through a small byte-wide write/read port. It can start, stop and clear the counter, pick the counting shape, and read back the live counting direction and the counter value. It also chooses whether the two outputs are complementary, with or without a dead band, or simply identical. Duty and period writes go to shadow copies, which move into the active copies only at the count's natural restart point.

Register addresses: 0 control, 1 duty shadow, 2 period shadow, 3 prescale, 4 dead-band length, 5 counter value (read only).

Top module: `pwm_phase_gen`

## Requirements
- R1: After reset the control register (address 0; bit0 run, bit1 clear, bit2 center mode, bit3 direction-up read-only, bit4 dead-band enable, bit5 complementary pairing) reads 0x38, the counter reads 0 and out_hi is 0.
- R2: While the run bit is 0, the counter and its prescaler hold their values.
- R3: In classical mode with active period P, the counter (readable at address 5) steps 0,1,..,P,0,.., and the direction bit reads 1.
- R4: In center mode the counter steps 0 up to P, then down to 0, and repeats. The direction bit reads 1 from 0 up to and including P, and 0 on the way down.
- R5: Writing 1 to the clear bit zeroes counter and prescaler one clock later. The clear bit reads 1 only in the cycle after the write and 0 afterwards.
- R6: The compare signal is active exactly while the counter is below the active duty value.
- R7: Writes to duty (address 1) and period (address 2) reach the counting only when the counter restarts from zero, or on a clear.
- R8: With dead band enabled and pairing complementary, each rising edge of out_hi and out_lo is delayed by the dead-band length D (address 4) clocks. Each output's high time per period is therefore D clocks shorter.
- R9: With dead band disabled and pairing complementary, out_lo is the exact inverse of out_hi.
- R10: With the pairing bit 0, out_hi and out_lo carry the same compare signal.
- R11: With complementary pairing, out_hi and out_lo are never both 1.
- R12: With prescale value S (address 3), the counter advances once every S+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| out_hi | output | 1 | High-side drive |
| out_lo | output | 1 | Low-side drive |

## Verification
The assertions check the following on every cycle:
- The outputs never overlap while pairing is complementary.
- The count never exceeds the active period.
- The count holds while stopped.
- The clear bit self-clears.
- The direction flag is forced up in classical mode.

Only the bench scenarios can show the other behaviours:
- the exact sawtooth and triangle sequences;
- the prescaler's step rate;
- the deferred adoption of a shadowed period;
- the high-time loss that the dead band causes.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  localparam int CB_RUN    = 0;
  localparam int CB_CLR    = 1;
  localparam int CB_CENTER = 2;
  localparam int CB_DIR    = 3;
  localparam int CB_DTEN   = 4;
  localparam int CB_PAIR   = 5;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_DUTY = 3'd1,
    A_PER  = 3'd2,
    A_PSC  = 3'd3,
    A_DT   = 3'd4,
    A_CNT  = 3'd5
  } addr_e;

  typedef struct packed {
    logic pair_comp;
    logic dt_en;
    logic center;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_phase_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CW     = 8,
  parameter int PW     = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CW-1:0]     cnt,
  input  logic              dir_up,
  output ctrl_t             ctrl,
  output logic              clr,
  output logic [CW-1:0]     duty_sh,
  output logic [CW-1:0]     per_sh,
  output logic [PW-1:0]     psc_val,
  output logic [DW-1:0]     dt_val,
  output logic [DATA_W-1:0] rdata
);
  ctrl_t          ctrl_q, ctrl_d;
  logic           clr_q, clr_d;
  logic [CW-1:0]  duty_q, duty_d, per_q, per_d;
  logic [PW-1:0]  psc_q, psc_d;
  logic [DW-1:0]  dt_q, dt_d;

  always_comb begin
    ctrl_d = ctrl_q;
    clr_d  = 1'b0;
    duty_d = duty_q;
    per_d  = per_q;
    psc_d  = psc_q;
    dt_d   = dt_q;
    if (wr) begin
      case (addr_e'(addr))
        A_CTRL: begin
          ctrl_d.run       = wdata[CB_RUN];
          ctrl_d.center    = wdata[CB_CENTER];
          ctrl_d.dt_en     = wdata[CB_DTEN];
          ctrl_d.pair_comp = wdata[CB_PAIR];
          clr_d            = wdata[CB_CLR];
        end
        A_DUTY:  duty_d = wdata[CW-1:0];
        A_PER:   per_d  = wdata[CW-1:0];
        A_PSC:   psc_d  = wdata[PW-1:0];
        A_DT:    dt_d   = wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{pair_comp: 1'b1, dt_en: 1'b1, center: 1'b0, run: 1'b0};
      clr_q  <= 1'b0;
      duty_q <= '0;
      per_q  <= '0;
      psc_q  <= '0;
      dt_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      clr_q  <= clr_d;
      duty_q <= duty_d;
      per_q  <= per_d;
      psc_q  <= psc_d;
      dt_q   <= dt_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr_e'(addr))
      A_CTRL: begin
        rdata[CB_RUN]    = ctrl_q.run;
        rdata[CB_CLR]    = clr_q;
        rdata[CB_CENTER] = ctrl_q.center;
        rdata[CB_DIR]    = dir_up;
        rdata[CB_DTEN]   = ctrl_q.dt_en;
        rdata[CB_PAIR]   = ctrl_q.pair_comp;
      end
      A_DUTY:  rdata = DATA_W'(duty_q);
      A_PER:   rdata = DATA_W'(per_q);
      A_PSC:   rdata = DATA_W'(psc_q);
      A_DT:    rdata = DATA_W'(dt_q);
      A_CNT:   rdata = DATA_W'(cnt);
      default: rdata = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign clr     = clr_q;
  assign duty_sh = duty_q;
  assign per_sh  = per_q;
  assign psc_val = psc_q;
  assign dt_val  = dt_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 8,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic          center,
  input  logic [PW-1:0] psc_val,
  input  logic [CW-1:0] duty_sh,
  input  logic [CW-1:0] per_sh,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] per_act,
  output logic          dir_up,
  output logic          cmp
);
  logic [PW-1:0] psc_q, psc_d;
  logic [CW-1:0] cnt_q, cnt_d, duty_a_q, duty_a_d, per_a_q, per_a_d;
  logic          dir_q, dir_d;
  logic          tick, reload;

  assign tick = run && (psc_q == psc_val);

  always_comb begin
    psc_d  = psc_q;
    cnt_d  = cnt_q;
    dir_d  = center ? dir_q : 1'b1;
    reload = 1'b0;
    if (clr) begin
      psc_d  = '0;
      cnt_d  = '0;
      dir_d  = 1'b1;
      reload = 1'b1;
    end else if (run) begin
      psc_d = tick ? '0 : psc_q + PW'(1);
      if (tick) begin
        if (!center) begin
          if (cnt_q >= per_a_q) begin
            cnt_d  = '0;
            reload = 1'b1;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end else if (dir_q) begin
          if (cnt_q >= per_a_q) begin
            if (per_a_q == '0) begin
              cnt_d  = '0;
              reload = 1'b1;
            end else begin
              cnt_d = cnt_q - CW'(1);
              dir_d = 1'b0;
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end else begin
          if (cnt_q <= CW'(1)) begin
            cnt_d  = '0;
            dir_d  = 1'b1;
            reload = 1'b1;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
      end
    end
    duty_a_d = reload ? duty_sh : duty_a_q;
    per_a_d  = reload ? per_sh  : per_a_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q    <= '0;
      cnt_q    <= '0;
      dir_q    <= 1'b1;
      duty_a_q <= '0;
      per_a_q  <= '0;
    end else begin
      psc_q    <= psc_d;
      cnt_q    <= cnt_d;
      dir_q    <= dir_d;
      duty_a_q <= duty_a_d;
      per_a_q  <= per_a_d;
    end
  end

  assign cnt     = cnt_q;
  assign per_act = per_a_q;
  assign dir_up  = dir_q;
  assign cmp     = cnt_q < duty_a_q;
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp,
  input  logic          dt_en,
  input  logic          pair_comp,
  input  logic [DW-1:0] dt_val,
  output logic          out_hi,
  output logic          out_lo
);
  logic          cmp_q;
  logic [DW-1:0] dt_q, dt_d;
  logic          gate_open;
  logic          hi_q, hi_d, lo_q, lo_d;

  always_comb begin
    if (!dt_en)              dt_d = '0;
    else if (cmp != cmp_q)   dt_d = dt_val;
    else if (dt_q != '0)     dt_d = dt_q - DW'(1);
    else                     dt_d = dt_q;
    gate_open = (dt_d == '0);
    if (!pair_comp) begin
      hi_d = cmp;
      lo_d = cmp;
    end else if (!dt_en) begin
      hi_d = cmp;
      lo_d = !cmp;
    end else begin
      hi_d = cmp  && gate_open;
      lo_d = !cmp && gate_open;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
      dt_q  <= '0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else begin
      cmp_q <= cmp;
      dt_q  <= dt_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  assign out_hi = hi_q;
  assign out_lo = lo_q;
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_phase_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CW        = 8,
  parameter int PW        = 8,
  parameter int DW        = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              out_hi,
  output logic              out_lo
);
  logic          rst_n_int;
  ctrl_t         ctrl;
  logic          clr_pulse, dir_up, cmp;
  logic [CW-1:0] duty_sh, per_sh, cnt, per_act;
  logic [PW-1:0] psc_val;
  logic [DW-1:0] dt_val;

  pwm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  pwm_regs #(.DATA_W(DATA_W), .CW(CW), .PW(PW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .cnt(cnt), .dir_up(dir_up), .ctrl(ctrl),
    .clr(clr_pulse), .duty_sh(duty_sh), .per_sh(per_sh),
    .psc_val(psc_val), .dt_val(dt_val), .rdata(reg_rdata)
  );

  pwm_timebase #(.CW(CW), .PW(PW)) u_tb (
    .clk(clk), .rst_n(rst_n_int), .run(ctrl.run), .clr(clr_pulse),
    .center(ctrl.center), .psc_val(psc_val), .duty_sh(duty_sh),
    .per_sh(per_sh), .cnt(cnt), .per_act(per_act), .dir_up(dir_up),
    .cmp(cmp)
  );

  pwm_deadband #(.DW(DW)) u_db (
    .clk(clk), .rst_n(rst_n_int), .cmp(cmp), .dt_en(ctrl.dt_en),
    .pair_comp(ctrl.pair_comp), .dt_val(dt_val),
    .out_hi(out_hi), .out_lo(out_lo)
  );
endmodule

// File: rtl/pwm_phase_chk.sv
module pwm_phase_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic          run,
  input logic          center,
  input logic          pair_comp,
  input logic          clr,
  input logic          dir_up,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] per_act,
  input logic          out_hi,
  input logic          out_lo
);
  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_comp && $past(pair_comp)) |-> !(out_hi && out_lo));

  // R2
  hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt));

  // R5
  clr_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(reg_wr && reg_addr == 3'd0)) |=> !clr);

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R3
  classic_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !center |=> dir_up);

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_act);
endmodule

bind pwm_phase_gen pwm_phase_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .run(ctrl.run), .center(ctrl.center), .pair_comp(ctrl.pair_comp),
  .clr(clr_pulse), .dir_up(dir_up), .cnt(cnt), .per_act(per_act),
  .out_hi(out_hi), .out_lo(out_lo)
);

// File: tb/test_pwm_phase_gen.sv
module test_pwm_phase_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       center;
    logic [7:0] per;
    logic [7:0] psc;
    logic [7:0] edges;
    logic [7:0] exp_cnt;
    logic       exp_dir;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd5, 8'd0, 8'd3, 8'd3, 1'b1},
    '{1'b0, 8'd5, 8'd0, 8'd6, 8'd0, 1'b1},
    '{1'b0, 8'd5, 8'd0, 8'd8, 8'd2, 1'b1},
    '{1'b0, 8'd4, 8'd2, 8'd7, 8'd2, 1'b1},
    '{1'b1, 8'd4, 8'd0, 8'd4, 8'd4, 1'b1},
    '{1'b1, 8'd4, 8'd0, 8'd5, 8'd3, 1'b0},
    '{1'b1, 8'd4, 8'd0, 8'd8, 8'd0, 1'b1},
    '{1'b1, 8'd4, 8'd0, 8'd9, 8'd1, 1'b1},
    '{1'b1, 8'd3, 8'd1, 8'd9, 8'd2, 1'b0},
    '{1'b0, 8'd0, 8'd0, 8'd5, 8'd0, 1'b1}
  };

  logic       clk, rst_n, reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       out_hi, out_lo;

  int checks = 0;
  int fails  = 0;
  logic dten_sel = 1'b1;
  logic pair_sel = 1'b1;

  pwm_phase_gen i_pwm_phase_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_hi(out_hi), .out_lo(out_lo)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] ctrl_byte(input logic run, input logic clr, input logic ctr);
    return {2'b00, pair_sel, dten_sel, 1'b0, ctr, clr, run};
  endfunction

  task automatic wait_edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart(input logic ctr);
    reg_write(3'd0, ctrl_byte(1'b1, 1'b1, ctr));
    wait_edges(1);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [7:0] rd, rd2;
    int hi_n, lo_n;
    string tag;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wait_edges(4);

    // R1 reset state
    reg_read(3'd0, rd);
    chk(rd == 8'h38, "R1 ctrl reset", rd, 8'h38);
    reg_read(3'd5, rd);
    chk(rd == 8'd0, "R1 counter reset", rd, 0);
    chk(out_hi == 1'b0, "R1 out_hi reset", out_hi, 0);

    // R3 R4 R12 table of counting patterns
    for (int i = 0; i < NV; i++) begin
      reg_write(3'd2, VECS[i].per);
      reg_write(3'd3, VECS[i].psc);
      restart(VECS[i].center);
      wait_edges(VECS[i].edges);
      tag = (VECS[i].psc != 0) ? "R12" : (VECS[i].center ? "R4" : "R3");
      reg_read(3'd5, rd);
      chk(rd == VECS[i].exp_cnt, {tag, " count"}, rd, VECS[i].exp_cnt);
      reg_read(3'd0, rd);
      chk(rd[3] == VECS[i].exp_dir, {tag, " direction"}, rd[3], VECS[i].exp_dir);
    end

    // R2 stop freezes counter
    reg_write(3'd2, 8'd9);
    reg_write(3'd3, 8'd0);
    restart(1'b0);
    wait_edges(3);
    reg_write(3'd0, ctrl_byte(1'b0, 1'b0, 1'b0));
    reg_read(3'd5, rd);
    chk(rd == 8'd4, "R2 count at stop", rd, 4);
    wait_edges(5);
    reg_read(3'd5, rd2);
    chk(rd2 == rd, "R2 held while stopped", rd2, rd);

    // R5 clear self-clears
    restart(1'b0);
    wait_edges(5);
    reg_write(3'd0, ctrl_byte(1'b1, 1'b1, 1'b0));
    reg_read(3'd0, rd);
    chk(rd[1] == 1'b1, "R5 clear bit set", rd[1], 1);
    wait_edges(1);
    reg_read(3'd0, rd);
    chk(rd[1] == 1'b0, "R5 clear bit returns", rd[1], 0);
    reg_read(3'd5, rd);
    chk(rd == 8'd0, "R5 counter cleared", rd, 0);

    // R7 shadowed period takes effect at wrap
    restart(1'b0);
    wait_edges(2);
    reg_write(3'd2, 8'd3);
    wait_edges(3);
    reg_read(3'd5, rd);
    chk(rd == 8'd6, "R7 old period still used", rd, 6);
    wait_edges(8);
    reg_read(3'd5, rd);
    chk(rd == 8'd0, "R7 new period after wrap", rd, 0);

    // R6 R9 R11 bypass: period 9, duty 4
    reg_write(3'd2, 8'd9);
    reg_write(3'd1, 8'd4);
    reg_write(3'd4, 8'd2);
    dten_sel = 1'b0; pair_sel = 1'b1;
    restart(1'b0);
    wait_edges(20);
    hi_n = 0; lo_n = 0;
    for (int c = 0; c < 100; c++) begin
      wait_edges(1);
      hi_n += int'(out_hi); lo_n += int'(out_lo);
      if (out_hi == out_lo) chk(1'b0, "R9 complement", out_lo, !out_hi);
    end
    chk(hi_n == 40, "R6 high-side time", hi_n, 40);
    chk(lo_n == 60, "R9 low-side time", lo_n, 60);

    // R8 R11 dead band of 2 clocks
    dten_sel = 1'b1;
    restart(1'b0);
    wait_edges(20);
    hi_n = 0; lo_n = 0;
    for (int c = 0; c < 100; c++) begin
      wait_edges(1);
      hi_n += int'(out_hi); lo_n += int'(out_lo);
      if (out_hi && out_lo) chk(1'b0, "R11 overlap", 1, 0);
    end
    chk(hi_n == 20, "R8 high-side time", hi_n, 20);
    chk(lo_n == 40, "R8 low-side time", lo_n, 40);

    // R10 identical outputs
    pair_sel = 1'b0;
    restart(1'b0);
    wait_edges(20);
    hi_n = 0;
    for (int c = 0; c < 100; c++) begin
      wait_edges(1);
      hi_n += int'(out_hi);
      if (out_hi != out_lo) chk(1'b0, "R10 same signal", out_lo, out_hi);
    end
    chk(hi_n == 40, "R10 shared high time", hi_n, 40);

    report();
  end
endmodule